// File: doc/BRIEF.md
# Vertical-Blank Staged Plane Suppression

This block sits beside one display pipe and decides, plane by plane, whether each plane's contents may reach the screen. Software programs two override controls: one that hides every display and overlay plane on the pipe, and one that hides every cursor plane on the pipe. While an override is in force, the plane's own programmed enable is masked off. The pipe's timing keeps running, so only the picture content goes dark.

A write to an override control does not act at once. The written value waits in a pending copy. It moves into the active copy on the next rising edge of the vertical-blank pulse from the pipe timing generator, so a plane never turns on or off partway through a frame. A status output stays high while any pending value still differs from its active value, so software can poll until the change has landed. A separate output tells the pixel path that the whole picture on the pipe is being blanked.

Top module: `pbc_plane_blank`

## Requirements
- R1: After a synchronous active-low reset, both override controls are 0 (normal operation). Every effective enable then equals its programmed enable, and `blank_pix` and `update_pending` are 0.
- R2: A write with `wr_data[0]`=1 (the display/overlay override) leaves `disp_en_eff` unchanged until the next rising edge of `vblank`. After that edge every bit of `disp_en_eff` is 0.
- R3: A later write with `wr_data[0]`=0 keeps the display planes hidden until the following rising edge of `vblank`. After that edge `disp_en_eff` equals `disp_en` again.
- R4: `wr_data[1]` is the cursor override. It is staged in the same way and masks `cur_en_eff`. It does not affect the display planes, and the display override does not affect the cursor planes.
- R5: Each effective enable is the plane's programmed enable ANDed with the inverse of its active override. Changes to `disp_en` and `cur_en` reach the outputs in the same cycle, whatever the override state.
- R6: When a write and a rising edge of `vblank` fall in the same cycle, the newly written value becomes active at that edge.
- R7: Only a rising edge of `vblank` loads the active copy. While `vblank` is held high, a write stays pending until `vblank` falls and rises again.
- R8: `update_pending` is 1 exactly when the pending and active copies of either override differ. It clears after the loading edge.
- R9: `blank_pix` is 1 exactly while the display/overlay override is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipe clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the override controls |
| wr_data | input | 2 | Bit 0 display/overlay override, bit 1 cursor override |
| vblank | input | 1 | Vertical-blank level from the timing generator |
| disp_en | input | NUM_DISP | Programmed enables of display and overlay planes |
| cur_en | input | NUM_CUR | Programmed enables of cursor planes |
| disp_en_eff | output | NUM_DISP | Effective display/overlay plane enables |
| cur_en_eff | output | NUM_CUR | Effective cursor plane enables |
| blank_pix | output | 1 | Whole picture on the pipe is blanked |
| update_pending | output | 1 | A written override value has not yet taken effect |

## Verification
The checker judges a rising edge of `vblank` from the pin's values in the last two samples. It therefore takes for granted that `vblank` is low while reset is held and for the first sample after reset is released, so that the pin history matches the block's own edge register. The bench holds `vblank` low through reset. It drives every input on the falling clock edge, so each pulse lasts a whole cycle. Programmed enables change only where the cursor and display change checks allow it, or where an override is in force and the masking relation is being checked.

// File: rtl/pbc_pkg.sv
// Package: shared definitions for the plane suppression block.
// Assumes: the write word carries one bit per override, in the order given by ovr_idx_e.
package pbc_pkg;
    // Index of each override control inside the write word
    typedef enum logic [0:0] {
        OVR_DISP = 1'b0,
        OVR_CUR  = 1'b1
    } ovr_idx_e;

    localparam int unsigned NUM_OVR = 2;

    // Pending and active copies of one override control
    typedef struct packed {
        logic pend;
        logic act;
    } ovr_state_t;
endpackage

// File: rtl/pbc_edge_detect.sv
// Module: finds the rising edge of a level input.
// Assumes: the input is synchronous to clk; the output pulses for one cycle.
module pbc_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic lvl_q;

    // Remember the level seen at the previous edge
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    // A rise is a high level now that was low one cycle ago
    always_comb begin
        rise = lvl & ~lvl_q;
    end
endmodule

// File: rtl/pbc_override_reg.sv
// Module: one override control with a pending copy written by software
// and an active copy that loads from it at a vertical-blank edge.
// Assumes: load is a single-cycle pulse; a write in the load cycle wins.
module pbc_override_reg
    import pbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_bit,
    input  logic       load,
    output ovr_state_t st,
    output logic       differ
);
    logic pend_q;
    logic act_q;
    logic pend_nxt;

    // Value the pending copy takes at this edge
    always_comb begin
        pend_nxt = wr_en ? wr_bit : pend_q;
    end

    // Pending copy follows software writes
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_nxt;
    end

    // Active copy loads at the edge, including a same-cycle write
    always_ff @(posedge clk) begin
        if (!rst_n)    act_q <= 1'b0;
        else if (load) act_q <= pend_nxt;
    end

    // Export state and mismatch flag
    always_comb begin
        st.pend = pend_q;
        st.act  = act_q;
        differ  = pend_q ^ act_q;
    end
endmodule

// File: rtl/pbc_plane_mask.sv
// Module: masks a group of plane enables with one active override.
// Assumes: the override is already synchronised to frame boundaries.
module pbc_plane_mask #(
    parameter int unsigned WIDTH = 2
) (
    input  logic [WIDTH-1:0] en_in,
    input  logic             hide,
    output logic [WIDTH-1:0] en_out
);
    // Mask each plane with the shared override
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign en_out[i] = en_in[i] & ~hide;
    end
endmodule

// File: rtl/pbc_plane_blank.sv
// Module: top of the plane suppression block for one pipe.
// Assumes: vblank is a level from the pipe timing generator, synchronous to clk;
// the plane enables come straight from programmed registers.
module pbc_plane_blank
    import pbc_pkg::*;
#(
    parameter int unsigned NUM_DISP = 3,
    parameter int unsigned NUM_CUR  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [NUM_OVR-1:0]  wr_data,
    input  logic                vblank,
    input  logic [NUM_DISP-1:0] disp_en,
    input  logic [NUM_CUR-1:0]  cur_en,
    output logic [NUM_DISP-1:0] disp_en_eff,
    output logic [NUM_CUR-1:0]  cur_en_eff,
    output logic                blank_pix,
    output logic                update_pending
);
    logic                      vb_rise;
    ovr_state_t [NUM_OVR-1:0]  ovr_st;
    logic       [NUM_OVR-1:0]  ovr_diff;

    pbc_edge_detect u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (vblank),
        .rise  (vb_rise)
    );

    for (genvar k = 0; k < NUM_OVR; k++) begin : g_ovr
        pbc_override_reg u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_en),
            .wr_bit (wr_data[k]),
            .load   (vb_rise),
            .st     (ovr_st[k]),
            .differ (ovr_diff[k])
        );
    end

    pbc_plane_mask #(.WIDTH(NUM_DISP)) u_mask_disp (
        .en_in  (disp_en),
        .hide   (ovr_st[OVR_DISP].act),
        .en_out (disp_en_eff)
    );

    pbc_plane_mask #(.WIDTH(NUM_CUR)) u_mask_cur (
        .en_in  (cur_en),
        .hide   (ovr_st[OVR_CUR].act),
        .en_out (cur_en_eff)
    );

    // Drive status outputs from the active and pending copies
    always_comb begin
        blank_pix      = ovr_st[OVR_DISP].act;
        update_pending = |ovr_diff;
    end
endmodule

// File: rtl/pbc_plane_blank_chk.sv
// Checker: temporal properties of the plane suppression block, bound to the top.
// Assumes: vblank is low during reset and for the first cycle after it.
module pbc_plane_blank_chk #(
    parameter int unsigned NUM_DISP = 3,
    parameter int unsigned NUM_CUR  = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [1:0]          wr_data,
    input logic                vblank,
    input logic [NUM_DISP-1:0] disp_en,
    input logic [NUM_CUR-1:0]  cur_en,
    input logic [NUM_DISP-1:0] disp_en_eff,
    input logic [NUM_CUR-1:0]  cur_en_eff,
    input logic                blank_pix,
    input logic                update_pending
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!update_pending && !blank_pix)); // R1

    AST_DISP_ONLY_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $changed(blank_pix)) |-> ($past(vblank) && !$past(vblank, 2))); // R2

    AST_CUR_ONLY_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $changed(cur_en_eff) && $stable(cur_en))
        |-> ($past(vblank) && !$past(vblank, 2))); // R4

    AST_MASK_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_pix |-> (disp_en_eff == disp_en)); // R5

    AST_MASK_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        blank_pix |-> (disp_en_eff == '0)); // R9

    AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && vblank && !$past(vblank) && $past(rst_n)) |=> !update_pending); // R6

    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!update_pending && !wr_en) |=> !update_pending); // R8
endmodule

bind pbc_plane_blank pbc_plane_blank_chk #(
    .NUM_DISP(NUM_DISP),
    .NUM_CUR (NUM_CUR)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .vblank         (vblank),
    .disp_en        (disp_en),
    .cur_en         (cur_en),
    .disp_en_eff    (disp_en_eff),
    .cur_en_eff     (cur_en_eff),
    .blank_pix      (blank_pix),
    .update_pending (update_pending)
);

// File: tb/sim_pbc_plane_blank.sv
module sim_pbc_plane_blank;
    localparam int  ND         = 3;
    localparam int  NC         = 2;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en;
    logic [1:0]    wr_data;
    logic          vblank;
    logic [ND-1:0] disp_en;
    logic [NC-1:0] cur_en;
    logic [ND-1:0] disp_en_eff;
    logic [NC-1:0] cur_en_eff;
    logic          blank_pix;
    logic          update_pending;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pbc_plane_blank #(.NUM_DISP(ND), .NUM_CUR(NC)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .vblank(vblank), .disp_en(disp_en), .cur_en(cur_en),
        .disp_en_eff(disp_en_eff), .cur_en_eff(cur_en_eff),
        .blank_pix(blank_pix), .update_pending(update_pending)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic vb_pulse();
        @(negedge clk); vblank = 1'b1;
        @(negedge clk); vblank = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; vblank = 1'b0;
        disp_en = 3'b101; cur_en = 2'b11;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 disp", 8'(disp_en_eff), 8'(3'b101));
        check("R1 cur", 8'(cur_en_eff), 8'(2'b11));
        check("R1 blank", 8'(blank_pix), 8'd0);
        check("R1 pending", 8'(update_pending), 8'd0);
    endtask

    task automatic t_disp_stage();
        do_write(2'b01);
        check("R2 before edge", 8'(disp_en_eff), 8'(3'b101));
        check("R8 pending set", 8'(update_pending), 8'd1);
        vb_pulse();
        check("R2 after edge", 8'(disp_en_eff), 8'd0);
        check("R9 blank", 8'(blank_pix), 8'd1);
        check("R8 pending clear", 8'(update_pending), 8'd0);
        check("R4 cursor untouched", 8'(cur_en_eff), 8'(2'b11));
    endtask

    task automatic t_mask_live();
        @(negedge clk); disp_en = 3'b111; cur_en = 2'b01;
        #1;
        check("R5 masked disp", 8'(disp_en_eff), 8'd0);
        check("R5 cur follows", 8'(cur_en_eff), 8'(2'b01));
    endtask

    task automatic t_disp_resume();
        do_write(2'b00);
        check("R3 still hidden", 8'(disp_en_eff), 8'd0);
        vb_pulse();
        check("R3 resumed", 8'(disp_en_eff), 8'(3'b111));
        check("R9 unblank", 8'(blank_pix), 8'd0);
    endtask

    task automatic t_cursor();
        cur_en = 2'b11;
        do_write(2'b10);
        check("R4 cur before edge", 8'(cur_en_eff), 8'(2'b11));
        vb_pulse();
        check("R4 cur hidden", 8'(cur_en_eff), 8'd0);
        check("R4 disp independent", 8'(disp_en_eff), 8'(3'b111));
        check("R4 no blank", 8'(blank_pix), 8'd0);
        do_write(2'b00);
        vb_pulse();
        check("R4 cur resumed", 8'(cur_en_eff), 8'(2'b11));
    endtask

    task automatic t_same_cycle();
        @(negedge clk); wr_en = 1'b1; wr_data = 2'b11; vblank = 1'b1;
        @(negedge clk); wr_en = 1'b0; vblank = 1'b0;
        check("R6 disp", 8'(disp_en_eff), 8'd0);
        check("R6 cur", 8'(cur_en_eff), 8'd0);
        check("R6 pending", 8'(update_pending), 8'd0);
    endtask

    task automatic t_held_high();
        @(negedge clk); vblank = 1'b1;
        @(negedge clk);
        do_write(2'b00);
        repeat (3) @(negedge clk);
        check("R7 held hidden", 8'(disp_en_eff), 8'd0);
        check("R7 pending", 8'(update_pending), 8'd1);
        vblank = 1'b0;
        @(negedge clk);
        check("R7 fall no load", 8'(blank_pix), 8'd1);
        vb_pulse();
        check("R7 next rise", 8'(disp_en_eff), 8'(3'b111));
        check("R7 cur back", 8'(cur_en_eff), 8'(2'b11));
    endtask

    initial begin
        t_reset();
        t_disp_stage();
        t_mask_live();
        t_disp_resume();
        t_cursor();
        t_same_cycle();
        t_held_high();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule